// File: doc/BRIEF.md
# Four-Stage Watchdog Timer with Keyed Write Protection

This block is a watchdog timer for a large chip. A programmable prescaler divides the bus clock into ticks. A sequencer walks through four timeout stages in a fixed order. Each stage counts its own number of ticks. When a stage's count is reached, the block carries out that stage's action and moves to the next stage. The action is one of four: nothing, raise an interrupt, pulse the CPU reset, or pulse the system reset. After the last stage expires, the sequencer stops. Software keeps the sequence from advancing by feeding the watchdog, which sends it back to the first stage with a fresh count.

All writes arrive on a simple single-cycle register write port. The control, divider, period and feed registers accept writes only while the protection register is unlocked. Writing the 32-bit key 0x50D83AA1 to the protection register unlocks it. Writing any other value locks it again. The interrupt enable and clear registers are shared interrupt controls, so they are never locked. The two reset outputs are pulses whose widths are selected separately as powers of two bus clocks.

Top module: `staged_watchdog`

## Requirements
- R1: After reset, all four outputs are low. The watchdog is disabled, locked and at stage 0, with every period and the divider at zero.
- R2: While locked, writes to the control (offset 1), divider (offset 2), period (offsets 3 to 6) and feed (offset 7) registers are ignored. Writing 0x50D83AA1 to offset 0 unlocks the block, and writing any other value to offset 0 locks it.
- R3: A tick occurs every max(D,1) bus clocks, where D is the 16-bit divider. The first tick comes D clocks after the enable or feed edge.
- R4: The stages run in the order 0, 1, 2, 3. Stage i expires on its P-th tick, where P is the value at offset 3+i (a value of 0 behaves as 1). The tick count restarts from zero at the start of every stage.
- R5: Each stage has a 2-bit action field in control bits [5+2i:4+2i], encoded as 0 none, 1 interrupt, 2 CPU reset, 3 system reset. A stage set to none still advances.
- R6: After stage 3 expires, the sequencer halts and takes no further action until a feed or a disable.
- R7: An accepted write of any value to offset 7 restarts the prescaler and the tick count, and returns the sequencer to stage 0, including from the halted state.
- R8: Clearing control bit 0 (enable) stops counting and zeroes the tick count and the stage. Setting it again starts a full new sequence from stage 0.
- R9: A CPU reset action drives cpu_rst high for 2^N clocks, where N is control bits [14:12]. A system reset action drives sys_rst high for 2^M clocks, where M is control bits [17:15]. Each pulse starts in the cycle after the expiring tick edge.
- R10: An interrupt action sets a pending flag. irq_level equals pending AND interrupt enable (offset 8 bit 0) AND the level enable (control bit 2). Writing 1 to bit 0 of offset 9 clears the pending flag. Offsets 8 and 9 are never locked.
- R11: irq_edge pulses for one clock when the pending flag is set while the edge enable (control bit 1) and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register word offset |
| wr_data | input | 32 | Register write data |
| irq_level | output | 1 | Level interrupt, held until cleared |
| irq_edge | output | 1 | One-cycle interrupt pulse |
| cpu_rst | output | 1 | Stretched CPU reset pulse |
| sys_rst | output | 1 | Stretched system reset pulse |

## Verification
The assertions assume that each write is a single-cycle strobe. They also assume that an interrupt clear is never issued in the same cycle as an expiry that sets the pending flag, because in that cycle the set wins. The bench spaces its writes two clocks apart, and it clears the interrupt only after the sequencer has halted or while no interrupt stage is due. Pulse start times and widths are predicted from the programmed divider, periods and length codes. They are compared when each pulse ends, and any pulse with no prediction is reported.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int REG_AW = 4;
    localparam int DATA_W = 32;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h50D8_3AA1;

    localparam logic [REG_AW-1:0] RA_KEY    = 4'd0;
    localparam logic [REG_AW-1:0] RA_CTRL   = 4'd1;
    localparam logic [REG_AW-1:0] RA_DIV    = 4'd2;
    localparam logic [REG_AW-1:0] RA_PER0   = 4'd3;
    localparam logic [REG_AW-1:0] RA_FEED   = 4'd7;
    localparam logic [REG_AW-1:0] RA_IRQEN  = 4'd8;
    localparam logic [REG_AW-1:0] RA_IRQCLR = 4'd9;

    localparam int CB_EN   = 0;
    localparam int CB_EDGE = 1;
    localparam int CB_LVL  = 2;
    localparam int CB_BOOT = 3;
    localparam int CB_ACT  = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_CPU  = 2'd2,
        ACT_SYS  = 2'd3
    } act_e;
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    // A divider of zero behaves as one.
    assign limit = (div == '0) ? '0 : div - 1'b1;
    assign tick  = run & ~restart & (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || restart) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/swd_stretch.sv
module swd_stretch #(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len_sel,
    output logic             pulse
);
    localparam int PW = 1 << LEN_W;

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire) begin
            cnt_d = PW'(1) << len_sel;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog
    import swd_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int DIV_W      = 16,
    parameter int CNT_W      = 32,
    parameter int LEN_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_level,
    output logic              irq_edge,
    output logic              cpu_rst,
    output logic              sys_rst
);
    localparam int STG_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1;
    localparam int CB_CPU = CB_ACT + 2 * NUM_STAGES;
    localparam int CB_SYS = CB_CPU + LEN_W;
    localparam logic [STG_W-1:0] LAST_STG = STG_W'(NUM_STAGES - 1);
    localparam int NUM_RST = 2;

    typedef struct packed {
        logic                              unlocked;
        logic                              en;
        logic                              edge_en;
        logic                              lvl_en;
        logic                              boot_en;
        logic [NUM_STAGES-1:0][1:0]        act;
        logic [LEN_W-1:0]                  cpu_len;
        logic [LEN_W-1:0]                  sys_len;
        logic [DIV_W-1:0]                  div;
        logic [NUM_STAGES-1:0][CNT_W-1:0]  per;
        logic [CNT_W-1:0]                  cnt;
        logic [STG_W-1:0]                  stage;
        logic                              done;
        logic                              pend;
        logic                              edge_p;
        logic                              irq_en;
    } state_t;

    state_t st_d, st_q;

    logic wr_ok, feed_wr, clr_wr, tick, expire, irq_set;
    act_e cur_act;
    logic [NUM_RST-1:0]            rst_fire;
    logic [NUM_RST-1:0][LEN_W-1:0] rst_len;
    logic [NUM_RST-1:0]            rst_pulse;

    assign wr_ok   = wr_en & st_q.unlocked;
    assign feed_wr = wr_ok & (wr_addr == RA_FEED);
    assign clr_wr  = wr_en & (wr_addr == RA_IRQCLR) & wr_data[0];

    swd_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.en),
        .restart (feed_wr),
        .div     (st_q.div),
        .tick    (tick)
    );

    always_comb begin
        st_d    = st_q;
        expire  = 1'b0;
        cur_act = act_e'(st_q.act[st_q.stage]);

        // Protection key: always writable.
        if (wr_en && wr_addr == RA_KEY) begin
            st_d.unlocked = (wr_data == UNLOCK_KEY);
        end

        // Guarded registers.
        if (wr_ok) begin
            if (wr_addr == RA_CTRL) begin
                st_d.en      = wr_data[CB_EN];
                st_d.edge_en = wr_data[CB_EDGE];
                st_d.lvl_en  = wr_data[CB_LVL];
                st_d.boot_en = wr_data[CB_BOOT];
                st_d.act     = wr_data[CB_ACT +: 2*NUM_STAGES];
                st_d.cpu_len = wr_data[CB_CPU +: LEN_W];
                st_d.sys_len = wr_data[CB_SYS +: LEN_W];
            end
            if (wr_addr == RA_DIV) begin
                st_d.div = wr_data[DIV_W-1:0];
            end
            for (int i = 0; i < NUM_STAGES; i++) begin
                if (wr_addr == RA_PER0 + REG_AW'(i)) begin
                    st_d.per[i] = wr_data[CNT_W-1:0];
                end
            end
        end

        // Shared interrupt enable: never locked.
        if (wr_en && wr_addr == RA_IRQEN) begin
            st_d.irq_en = wr_data[0];
        end

        // Stage sequencer.
        if (!st_q.en || feed_wr) begin
            st_d.cnt   = '0;
            st_d.stage = '0;
            st_d.done  = 1'b0;
        end else if (tick && !st_q.done) begin
            if (({1'b0, st_q.cnt} + (CNT_W+1)'(1)) >= {1'b0, st_q.per[st_q.stage]}) begin
                expire   = 1'b1;
                st_d.cnt = '0;
                if (st_q.stage == LAST_STG) begin
                    st_d.done = 1'b1;
                end else begin
                    st_d.stage = st_q.stage + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        irq_set     = expire && (cur_act == ACT_IRQ);
        rst_fire[0] = expire && (cur_act == ACT_CPU);
        rst_fire[1] = expire && (cur_act == ACT_SYS);

        // Set wins over clear so an expiry is never lost.
        if (irq_set) begin
            st_d.pend = 1'b1;
        end else if (clr_wr) begin
            st_d.pend = 1'b0;
        end
        st_d.edge_p = irq_set & st_q.edge_en & st_q.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_len[0] = st_q.cpu_len;
    assign rst_len[1] = st_q.sys_len;

    for (genvar g = 0; g < NUM_RST; g++) begin : g_stretch
        swd_stretch #(.LEN_W(LEN_W)) u_str (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (rst_fire[g]),
            .len_sel (rst_len[g]),
            .pulse   (rst_pulse[g])
        );
    end

    assign cpu_rst   = rst_pulse[0];
    assign sys_rst   = rst_pulse[1];
    assign irq_level = st_q.pend & st_q.irq_en & st_q.lvl_en;
    assign irq_edge  = st_q.edge_p;
endmodule

// File: rtl/swd_checker.sv
module swd_checker
    import swd_pkg::*;
#(
    parameter int STG_W = 2,
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_level,
    input logic              cpu_rst,
    input logic              sys_rst,
    input logic              unlocked,
    input logic              en,
    input logic [STG_W-1:0]  stage,
    input logic [CNT_W-1:0]  cnt,
    input logic              done,
    input logic              irq_set
);
    p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && wr_addr == RA_CTRL) |=> (en == $past(en)));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != $past(stage)) |-> ((stage == $past(stage) + 1'b1) || (stage == '0)));

    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> (!$rose(cpu_rst) && !$rose(sys_rst)));

    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (cnt == '0 && stage == '0 && !done));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_IRQCLR && wr_data[0] && !irq_set) |=> !irq_level);
endmodule

bind staged_watchdog swd_checker #(.STG_W(STG_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq_level (irq_level),
    .cpu_rst   (cpu_rst),
    .sys_rst   (sys_rst),
    .unlocked  (st_q.unlocked),
    .en        (st_q.en),
    .stage     (st_q.stage),
    .cnt       (st_q.cnt),
    .done      (st_q.done),
    .irq_set   (irq_set)
);

// File: tb/staged_watchdog_test.sv
module staged_watchdog_test;
    import swd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq_level, irq_edge, cpu_rst, sys_rst;

    staged_watchdog uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .irq_level (irq_level),
        .irq_edge  (irq_edge),
        .cpu_rst   (cpu_rst),
        .sys_rst   (sys_rst)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int last_edge = 0;
    int edge_cnt = 0;
    bit finished = 1'b0;

    int q_cpu_s[$], q_cpu_l[$], q_sys_s[$], q_sys_l[$], q_irq_s[$];

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive one write; returns right after the capturing edge.
    task automatic wr_edge(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 last_edge = cyc;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        wr_edge(a, d);
        idle();
    endtask

    function automatic logic [31:0] ctrl(bit en, bit edg, bit lvl,
                                         logic [1:0] a0, logic [1:0] a1,
                                         logic [1:0] a2, logic [1:0] a3,
                                         logic [2:0] cl, logic [2:0] sl);
        return 32'(en) | (32'(edg) << 1) | (32'(lvl) << 2) |
               (32'(a0) << 4) | (32'(a1) << 6) | (32'(a2) << 8) | (32'(a3) << 10) |
               (32'(cl) << 12) | (32'(sl) << 15);
    endfunction

    task automatic exp_cpu(int s, int l); q_cpu_s.push_back(s); q_cpu_l.push_back(l); endtask
    task automatic exp_sys(int s, int l); q_sys_s.push_back(s); q_sys_l.push_back(l); endtask

    // Monitor: pops expected items as pulses complete.
    bit p_cpu = 0, p_sys = 0, p_irq = 0;
    int t_cpu = 0, t_sys = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_edge) edge_cnt++;
            if (cpu_rst && !p_cpu) t_cpu = cyc;
            if (!cpu_rst && p_cpu) begin
                if (q_cpu_s.size() == 0) check(0, "R5 unexpected cpu_rst pulse", t_cpu, -1);
                else begin
                    int s, l;
                    s = q_cpu_s.pop_front(); l = q_cpu_l.pop_front();
                    check(t_cpu == s, "R4 cpu_rst start cycle", t_cpu, s);
                    check(cyc - t_cpu == l, "R9 cpu_rst width", cyc - t_cpu, l);
                end
            end
            if (sys_rst && !p_sys) t_sys = cyc;
            if (!sys_rst && p_sys) begin
                if (q_sys_s.size() == 0) check(0, "R5 unexpected sys_rst pulse", t_sys, -1);
                else begin
                    int s, l;
                    s = q_sys_s.pop_front(); l = q_sys_l.pop_front();
                    check(t_sys == s, "R4 sys_rst start cycle", t_sys, s);
                    check(cyc - t_sys == l, "R9 sys_rst width", cyc - t_sys, l);
                end
            end
            if (irq_level && !p_irq) begin
                if (q_irq_s.size() == 0) check(0, "R10 unexpected irq_level rise", cyc, -1);
                else begin
                    int s;
                    s = q_irq_s.pop_front();
                    check(cyc == s, "R10 irq_level rise cycle", cyc, s);
                end
            end
            p_cpu = cpu_rst; p_sys = sys_rst; p_irq = irq_level;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        int e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check({irq_level, irq_edge, cpu_rst, sys_rst} == 4'b0, "R1 outputs after reset",
              int'({irq_level, irq_edge, cpu_rst, sys_rst}), 0);

        // R2: locked control write must not enable (period 0 would fire at once)
        wr(RA_CTRL, ctrl(1, 1, 1, ACT_CPU, ACT_CPU, ACT_CPU, ACT_CPU, 0, 0));
        repeat (20) @(negedge clk);
        check(cpu_rst == 1'b0, "R2 locked write ignored", int'(cpu_rst), 0);

        // R4 R5 R6 R9 R11: full four-stage run, divider 1
        wr(RA_KEY, UNLOCK_KEY);
        wr(RA_DIV, 1);
        wr(4'd3, 3); wr(4'd4, 4); wr(4'd5, 2); wr(4'd6, 5);
        wr(RA_IRQEN, 1);
        wr_edge(RA_CTRL, ctrl(1, 1, 1, ACT_CPU, ACT_IRQ, ACT_NONE, ACT_SYS, 2, 0));
        e = last_edge;
        exp_cpu(e + 3, 4);
        q_irq_s.push_back(e + 7);
        exp_sys(e + 14, 1);
        idle();
        repeat (80) @(negedge clk);
        check(q_cpu_s.size() + q_sys_s.size() + q_irq_s.size() == 0, "R6 all stage actions seen",
              q_cpu_s.size() + q_sys_s.size() + q_irq_s.size(), 0);
        check(edge_cnt == 1, "R11 single edge pulse", edge_cnt, 1);
        check(irq_level == 1'b1, "R10 level held while pending", int'(irq_level), 1);
        wr(RA_IRQCLR, 1);
        check(irq_level == 1'b0, "R10 clear drops level", int'(irq_level), 0);

        // R3 R2 R7: divider 3; locked feed ignored, then accepted feed from halt
        wr(RA_CTRL, 0);
        wr(RA_DIV, 3);
        wr(4'd3, 10);
        wr_edge(RA_CTRL, ctrl(1, 0, 0, ACT_CPU, ACT_NONE, ACT_NONE, ACT_NONE, 3, 0));
        e = last_edge;
        exp_cpu(e + 30, 8);
        idle();
        wr(RA_KEY, 32'h89AB_CDEF);
        wr(RA_FEED, 0);
        repeat (90) @(negedge clk);
        check(q_cpu_s.size() == 0, "R2 locked feed ignored", q_cpu_s.size(), 0);
        wr(RA_KEY, UNLOCK_KEY);
        wr_edge(RA_FEED, 32'h1234);
        exp_cpu(last_edge + 30, 8);
        idle();
        repeat (50) @(negedge clk);
        check(q_cpu_s.size() == 0, "R7 feed restarts stage 0", q_cpu_s.size(), 0);

        // R8: disable before expiry, then re-enable starts fresh
        wr(RA_FEED, 0);
        wr(RA_CTRL, ctrl(0, 0, 0, ACT_CPU, ACT_NONE, ACT_NONE, ACT_NONE, 3, 0));
        repeat (80) @(negedge clk);
        check(cpu_rst == 1'b0, "R8 disable stops sequence", int'(cpu_rst), 0);
        wr_edge(RA_CTRL, ctrl(1, 0, 0, ACT_CPU, ACT_NONE, ACT_NONE, ACT_NONE, 3, 0));
        exp_cpu(last_edge + 30, 8);
        idle();
        repeat (50) @(negedge clk);
        check(q_cpu_s.size() == 0, "R8 re-enable full period", q_cpu_s.size(), 0);

        // R10 R11: interrupt enable gates level and edge
        wr(RA_CTRL, 0);
        wr(RA_IRQEN, 0);
        wr(4'd3, 2);
        wr(RA_CTRL, ctrl(1, 1, 1, ACT_IRQ, ACT_NONE, ACT_NONE, ACT_NONE, 0, 0));
        repeat (20) @(negedge clk);
        check(irq_level == 1'b0, "R10 level masked by enable", int'(irq_level), 0);
        check(edge_cnt == 1, "R11 edge masked by enable", edge_cnt, 1);
        wr_edge(RA_IRQEN, 1);
        q_irq_s.push_back(last_edge);
        idle();
        repeat (5) @(negedge clk);
        check(q_irq_s.size() == 0, "R10 pending shown after enable", q_irq_s.size(), 0);
        wr(RA_IRQCLR, 1);
        check(irq_level == 1'b0, "R10 clear after enable", int'(irq_level), 0);

        // R3: divider zero behaves as one
        wr(RA_CTRL, 0);
        wr(RA_DIV, 0);
        wr(4'd3, 5);
        wr_edge(RA_CTRL, ctrl(1, 0, 0, ACT_CPU, ACT_NONE, ACT_NONE, ACT_NONE, 0, 0));
        exp_cpu(last_edge + 5, 1);
        idle();
        repeat (40) @(negedge clk);
        check(q_cpu_s.size() == 0, "R3 divider zero", q_cpu_s.size(), 0);

        check(q_cpu_s.size() + q_sys_s.size() + q_irq_s.size() == 0, "R4 no missing events",
              q_cpu_s.size() + q_sys_s.size() + q_irq_s.size(), 0);
        summary();
    end
endmodule